// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two parallel buses, called A and B, and moves data between them in either direction. Each direction has a capture register. A direction can pass the live value of the opposite bus, or it can replay the value it captured earlier. The datapath is split into independent groups of `GRP_W` bits (two groups of eight by default). Every group has its own capture strobes, source selects and output enables, so one group can stream live data while another replays stored data.

Real tristate pins are replaced by three signals per bus: a resolved input value, an output value and a per-bit drive enable. The surrounding logic builds the actual bus from these. The drive enable for the B side is active high (`oe_ab`) and the one for the A side is active low (`oe_ba_n`). Captures happen on the rising edge of `clk` whenever the group's strobe is high, whatever the selects and enables are. This means a bus that is only being listened to can still be recorded. When one direction passes live data and both strobes fire together, both registers load the same bus value. Both directions can also replay their stored values at the same time, which swaps the two buses' earlier contents.

Top module: `dual_bus_xcvr`

## Requirements
- R1: When `cap_ab[g]` is high at a rising `clk` edge, the A-to-B register of group g loads that group's `a_in` bits, whatever the values of `sel_ab`, `sel_ba`, `oe_ab` and `oe_ba_n`.
- R2: When `cap_ba[g]` is high at a rising `clk` edge, the B-to-A register of group g loads that group's `b_in` bits, whatever the values of the selects and enables.
- R3: All `b_oe` bits of group g equal `oe_ab[g]` (1 = drive). While a group is not driven, its `b_out` bits read 0.
- R4: All `a_oe` bits of group g equal the inverse of `oe_ba_n[g]` (0 on `oe_ba_n` = drive). While a group is not driven, its `a_out` bits read 0.
- R5: While group g drives B, `sel_ab[g]`=0 puts the live `a_in` bits on `b_out` within the same cycle, and `sel_ab[g]`=1 puts the stored A-to-B register on `b_out`.
- R6: While group g drives A, `sel_ba[g]`=0 puts the live `b_in` bits on `a_out` within the same cycle, and `sel_ba[g]`=1 puts the stored B-to-A register on `a_out`.
- R7: A register whose strobe is low at an edge keeps its value, even when the bus it samples changes.
- R8: `rst_n` low at a rising edge clears both registers of every group to zero, and this overrides any strobe.
- R9: Group g covers bits [g*GRP_W +: GRP_W]. The controls of one group never affect another group's bits.
- R10: With B driven from live A and both strobes fired at the same edge, both registers of that group hold the same A value.
- R11: With `oe_ab`=1, `oe_ba_n`=0 and both selects at 1, `b_out` shows the stored A value and `a_out` shows the stored B value in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Synchronous active-low clear of all registers |
| a_in | input | GRP_W*GROUPS | Resolved value of bus A |
| b_in | input | GRP_W*GROUPS | Resolved value of bus B |
| cap_ab | input | GROUPS | Per-group strobe loading the A-to-B register |
| cap_ba | input | GROUPS | Per-group strobe loading the B-to-A register |
| sel_ab | input | GROUPS | B-side source: 0 live A, 1 stored |
| sel_ba | input | GROUPS | A-side source: 0 live B, 1 stored |
| oe_ab | input | GROUPS | Drive bus B, active high |
| oe_ba_n | input | GROUPS | Drive bus A, active low |
| a_out | output | GRP_W*GROUPS | Value driven onto bus A |
| a_oe | output | GRP_W*GROUPS | Per-bit drive enable for bus A |
| b_out | output | GRP_W*GROUPS | Value driven onto bus B |
| b_oe | output | GRP_W*GROUPS | Per-bit drive enable for bus B |

## Verification
Capture and replay can happen in the same cycle. While a strobe is high and that direction replays its register, the output must still show the old content, and it must show the new content only after the edge. The bench sets up this case with the select held at stored and a fresh value on the sampled bus. It compares the output a moment after the inputs settle and again after the edge. Reset and a strobe arriving at the same edge are also combined, and the expected result there is zero.

// File: rtl/dual_bus_xcvr.sv
module dual_bus_xcvr #(
  parameter int GRP_W  = 8,
  parameter int GROUPS = 2,
  localparam int W     = GRP_W * GROUPS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      a_in,
  input  logic [W-1:0]      b_in,
  input  logic [GROUPS-1:0] cap_ab,
  input  logic [GROUPS-1:0] cap_ba,
  input  logic [GROUPS-1:0] sel_ab,
  input  logic [GROUPS-1:0] sel_ba,
  input  logic [GROUPS-1:0] oe_ab,
  input  logic [GROUPS-1:0] oe_ba_n,
  output logic [W-1:0]      a_out,
  output logic [W-1:0]      a_oe,
  output logic [W-1:0]      b_out,
  output logic [W-1:0]      b_oe
);

  for (genvar g = 0; g < GROUPS; g++) begin : grp
    localparam int LO = g * GRP_W;
    logic [GRP_W-1:0] st_ab, st_ba;
    logic drv_a;

    always_ff @(posedge clk) begin
      if (!rst_n)          st_ab <= '0;
      else if (cap_ab[g])  st_ab <= a_in[LO +: GRP_W];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)          st_ba <= '0;
      else if (cap_ba[g])  st_ba <= b_in[LO +: GRP_W];
    end

    assign drv_a = ~oe_ba_n[g];

    assign b_oe[LO +: GRP_W]  = {GRP_W{oe_ab[g]}};
    assign b_out[LO +: GRP_W] = !oe_ab[g] ? '0 :
                                sel_ab[g] ? st_ab : a_in[LO +: GRP_W];

    assign a_oe[LO +: GRP_W]  = {GRP_W{drv_a}};
    assign a_out[LO +: GRP_W] = !drv_a    ? '0 :
                                sel_ba[g] ? st_ba : b_in[LO +: GRP_W];
  end

endmodule

// File: rtl/dual_bus_xcvr_chk.sv
module dual_bus_xcvr_chk #(
  parameter int GRP_W  = 8,
  parameter int GROUPS = 2,
  localparam int W     = GRP_W * GROUPS
) (
  input logic              clk,
  input logic              rst_n,
  input logic [W-1:0]      a_in,
  input logic [W-1:0]      b_in,
  input logic [GROUPS-1:0] cap_ab,
  input logic [GROUPS-1:0] cap_ba,
  input logic [GROUPS-1:0] sel_ab,
  input logic [GROUPS-1:0] sel_ba,
  input logic [GROUPS-1:0] oe_ab,
  input logic [GROUPS-1:0] oe_ba_n,
  input logic [W-1:0]      a_out,
  input logic [W-1:0]      a_oe,
  input logic [W-1:0]      b_out,
  input logic [W-1:0]      b_oe
);

  for (genvar g = 0; g < GROUPS; g++) begin : gc
    localparam int LO = g * GRP_W;

    p_cap_ab_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cap_ab[g] |=> (!(oe_ab[g] && sel_ab[g]) || b_out[LO +: GRP_W] == $past(a_in[LO +: GRP_W])));

    p_cap_ba_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cap_ba[g] |=> (!(!oe_ba_n[g] && sel_ba[g]) || a_out[LO +: GRP_W] == $past(b_in[LO +: GRP_W])));

    p_quiet_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_ab[g] |-> (b_oe[LO +: GRP_W] == '0 && b_out[LO +: GRP_W] == '0));

    p_quiet_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
      oe_ba_n[g] |-> (a_oe[LO +: GRP_W] == '0 && a_out[LO +: GRP_W] == '0));

    p_live_ab_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_ab[g] && !sel_ab[g]) |-> b_out[LO +: GRP_W] == a_in[LO +: GRP_W]);

    p_live_ba_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_ba_n[g] && !sel_ba[g]) |-> a_out[LO +: GRP_W] == b_in[LO +: GRP_W]);

    p_hold_ab_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_ab[g] && oe_ab[g] && sel_ab[g]) |=>
        (!(oe_ab[g] && sel_ab[g]) || $stable(b_out[LO +: GRP_W])));

    p_rst_ab_r8: assert property (@(posedge clk)
      !rst_n |=> (!(oe_ab[g] && sel_ab[g]) || b_out[LO +: GRP_W] == '0));

    p_rst_ba_r8: assert property (@(posedge clk)
      !rst_n |=> (!(!oe_ba_n[g] && sel_ba[g]) || a_out[LO +: GRP_W] == '0));
  end

endmodule

bind dual_bus_xcvr dual_bus_xcvr_chk #(.GRP_W(GRP_W), .GROUPS(GROUPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
  .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
  .oe_ab(oe_ab), .oe_ba_n(oe_ba_n),
  .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
);

// File: tb/test_dual_bus_xcvr.sv
module test_dual_bus_xcvr;
  localparam int GRP_W  = 8;
  localparam int GROUPS = 2;
  localparam int W      = GRP_W * GROUPS;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] a_in, b_in;
  logic [GROUPS-1:0] cap_ab, cap_ba, sel_ab, sel_ba, oe_ab, oe_ba_n;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  logic [W-1:0] m_ab, m_ba;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_bus_xcvr #(.GRP_W(GRP_W), .GROUPS(GROUPS)) i_dual_bus_xcvr (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .oe_ab(oe_ab), .oe_ba_n(oe_ba_n),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    logic [W-1:0] eb, ebo, ea, eao;
    #1;
    for (int g = 0; g < GROUPS; g++) begin
      ebo[g*GRP_W +: GRP_W] = {GRP_W{oe_ab[g]}};
      eb[g*GRP_W +: GRP_W]  = !oe_ab[g] ? '0 :
                              (sel_ab[g] ? m_ab[g*GRP_W +: GRP_W] : a_in[g*GRP_W +: GRP_W]);
      eao[g*GRP_W +: GRP_W] = {GRP_W{!oe_ba_n[g]}};
      ea[g*GRP_W +: GRP_W]  = oe_ba_n[g] ? '0 :
                              (sel_ba[g] ? m_ba[g*GRP_W +: GRP_W] : b_in[g*GRP_W +: GRP_W]);
    end
    chk(tag, "b_out", b_out, eb);
    chk(tag, "b_oe",  b_oe,  ebo);
    chk(tag, "a_out", a_out, ea);
    chk(tag, "a_oe",  a_oe,  eao);
  endtask

  task automatic edge_step();
    for (int g = 0; g < GROUPS; g++) begin
      if (!rst_n) begin
        m_ab[g*GRP_W +: GRP_W] = '0;
        m_ba[g*GRP_W +: GRP_W] = '0;
      end else begin
        if (cap_ab[g]) m_ab[g*GRP_W +: GRP_W] = a_in[g*GRP_W +: GRP_W];
        if (cap_ba[g]) m_ba[g*GRP_W +: GRP_W] = b_in[g*GRP_W +: GRP_W];
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    cap_ab = '0; cap_ba = '0;
  endtask

  // R8: reset clears both registers, even with strobes high in that edge
  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; a_in = 16'hA5C3; b_in = 16'h3C5A;
    cap_ab = '1; cap_ba = '1; sel_ab = '1; sel_ba = '1; oe_ab = '1; oe_ba_n = '0;
    m_ab = 16'hFFFF; m_ba = 16'hFFFF;
    edge_step();
    rst_n = 1'b1; quiet();
    compare("R8 reset");
  endtask

  // R1 R2 R3 R4: capture while isolated, then reveal
  task automatic t_isolate();
    oe_ab = '0; oe_ba_n = '1; sel_ab = '1; sel_ba = '0;
    a_in = 16'h1234; b_in = 16'hBEEF; cap_ab = '1; cap_ba = '1;
    compare("R3 R4 isolation");
    edge_step();
    quiet(); a_in = 16'h0F0F; b_in = 16'hF0F0;
    compare("R3 R4 isolation after edge");
    oe_ab = '1; oe_ba_n = '0; sel_ab = '1; sel_ba = '1;
    compare("R1 R2 reveal stored (R11)");
    chk("R1 literal", "b_out", b_out, 16'h1234);
    chk("R2 literal", "a_out", a_out, 16'hBEEF);
  endtask

  // R5 R6: live pass-through, several patterns
  task automatic t_live();
    oe_ab = '1; oe_ba_n = '0; sel_ab = '0; sel_ba = '0; quiet();
    for (int i = 0; i < 4; i++) begin
      a_in = 16'h0001 << (i * 4) ^ 16'h5555;
      b_in = ~a_in ^ 16'h00FF;
      compare("R5 R6 live");
    end
    chk("R5 literal", "b_out", b_out, a_in);
  endtask

  // R7: no strobe, bus moves, stored output stays
  task automatic t_hold();
    oe_ab = '1; oe_ba_n = '0; sel_ab = '1; sel_ba = '1; quiet();
    a_in = 16'hDEAD; b_in = 16'hCAFE;
    edge_step();
    a_in = 16'h7777; b_in = 16'h8888;
    edge_step();
    compare("R7 hold");
    chk("R7 literal", "b_out", b_out, 16'h1234);
  endtask

  // Same cycle: strobe high while replaying; old value before edge, new after
  task automatic t_cap_replay();
    oe_ab = '1; sel_ab = '1; oe_ba_n = '0; sel_ba = '1;
    a_in = 16'h4242; cap_ab = '1;
    compare("R1 before edge");
    chk("R1 before edge", "b_out", b_out, 16'h1234);
    edge_step();
    quiet();
    compare("R1 after edge");
    chk("R1 after edge", "b_out", b_out, 16'h4242);
  endtask

  // R10: B driven from live A, both strobes: both registers get the A value
  task automatic t_store_both();
    oe_ab = '1; sel_ab = '0; oe_ba_n = '1; sel_ba = '1;
    a_in = 16'h6C39; b_in = a_in; cap_ab = '1; cap_ba = '1;
    compare("R10 live drive");
    edge_step();
    quiet(); a_in = 16'h0000; b_in = 16'h0000;
    sel_ab = '1; oe_ba_n = '0;
    compare("R10 both stored");
    chk("R10 literal", "a_out", a_out, 16'h6C39);
    chk("R10 literal", "b_out", b_out, 16'h6C39);
  endtask

  // R11: swap of stored values in both directions
  task automatic t_exchange();
    oe_ab = '1; oe_ba_n = '1; sel_ab = '1; sel_ba = '1;
    a_in = 16'h1111; b_in = 16'h2222; cap_ab = '1; cap_ba = '1;
    edge_step();
    quiet(); oe_ba_n = '0; a_in = 16'h9999; b_in = 16'hAAAA;
    compare("R11 exchange");
    chk("R11 literal", "b_out", b_out, 16'h1111);
    chk("R11 literal", "a_out", a_out, 16'h2222);
  endtask

  // R9: groups independent
  task automatic t_groups();
    oe_ab = 2'b11; sel_ab = 2'b10; oe_ba_n = 2'b01; sel_ba = 2'b11;
    a_in = 16'hABCD; b_in = 16'h5678; cap_ab = 2'b01; cap_ba = 2'b10;
    compare("R9 mixed before");
    edge_step();
    quiet(); a_in = 16'h3344;
    compare("R9 mixed after");
    chk("R9 literal", "b_out", b_out, 16'h1144);
    chk("R9 literal", "a_oe",  a_oe,  16'hFF00);
    chk("R9 literal", "a_out", a_out, 16'h5600);
  endtask

  initial begin
    rst_n = 1'b0; a_in = '0; b_in = '0;
    cap_ab = '0; cap_ba = '0; sel_ab = '0; sel_ba = '0; oe_ab = '0; oe_ba_n = '1;
    m_ab = '0; m_ba = '0;
    t_reset();
    t_isolate();
    t_live();
    t_hold();
    t_cap_replay();
    t_store_both();
    t_exchange();
    t_groups();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule